// File: doc/BRIEF.md
# Run-Length Steered Dual-Cache Probe Sequencer

This block sits beside a core's two private caches, one for user work and one for kernel work, and decides which of them each load or store probes first. It learns, per system call, how long the kernel stays in privileged mode. Each privileged entry looks up the learned class for the invoked call, and each return to user mode trains that class from a count of retired instructions.

Only a call classed as moderately long sends privileged accesses to the kernel cache first. Very short calls and very long calls, like all user-mode accesses, go to the user cache first. Both caches may hold the same line, so a miss in the first cache always probes the other one. The request is forwarded to the next level only when both probes miss. A global partition enable can turn steering off, so the pair then behaves as one shared cache searched user-side first.

Top module: `syscall_steer_top`

## Requirements
- R1: On a cycle with `priv_enter` high, the class for table slot `call_id[IDX_W-1:0]` is latched and used for privileged accesses until the next entry. Call numbers that share the low index bits share one slot.
- R2: A request accepted while the core is in user mode probes the user cache first (`probe_sel` = 0).
- R3: A request accepted in privileged mode with partitioning enabled probes the kernel cache first (`probe_sel` = 1) exactly when the latched class is moderate (class code 1).
- R4: In privileged mode, a latched class of short (code 0) or long (code 2) gives a user-first probe.
- R5: A request is taken only when `req_ready` is high. Its first probe is held on `probe_valid` until `rsp_valid`. A hit ends the access. A miss starts a second probe, on the next cycle, of the opposite cache.
- R6: When the second probe also misses, `fwd_valid` rises for exactly one cycle, the cycle after that response, with `fwd_addr` equal to the request address. It never rises after a hit.
- R7: A measured count no greater than `thr_short` is classed short. A count no less than `thr_long` is classed long. Any count between them is moderate.
- R8: A `priv_exit` while privileged overwrites the slot of the current call with the class of the measured count. A `priv_exit` in user mode changes nothing.
- R9: Reset sets every table slot to short and leaves the core in user mode with the sequencer idle.
- R10: With `part_en` low, every access probes the user cache first.
- R11: A `priv_enter` while already privileged restarts the count from zero for the new call, and the pending training of the earlier call is dropped.
- R12: The retired-instruction count saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| part_en | input | 1 | Partition enable; low forces user-first probes |
| thr_short | input | CNT_W | Largest count classed short |
| thr_long | input | CNT_W | Smallest count classed long |
| priv_enter | input | 1 | Pulse: entry to privileged mode |
| call_id | input | ID_W | System call number, sampled with priv_enter |
| priv_exit | input | 1 | Pulse: return to user mode |
| insn_retire | input | 1 | One instruction retired this cycle |
| req_valid | input | 1 | Load or store request |
| req_addr | input | ADDR_W | Request address |
| req_ready | output | 1 | Sequencer idle, request accepted |
| probe_valid | output | 1 | A cache probe is outstanding |
| probe_sel | output | 1 | Probed cache: 0 user, 1 kernel |
| rsp_valid | input | 1 | Probe response present |
| rsp_hit | input | 1 | Probe response hit |
| fwd_valid | output | 1 | Forward request to next level |
| fwd_addr | output | ADDR_W | Forwarded address |

## Verification
The bench builds the block with an 8-bit count (`CNT_W` = 8) and programs the thresholds to 3 and 8. With those values every class boundary is reached in a few cycles, and the count's saturation point, 255, is reached within a few hundred retires. A run of 260 retires then separates saturation, which gives a long class, from wrap-around, which gives a count of 4 and so a moderate class. Call numbers 9 and 73 both land in slot 9 of the default 64-slot table, so sharing of slots by aliasing call numbers is tested directly.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [1:0] {
    RL_SHORT = 2'd0,
    RL_MOD   = 2'd1,
    RL_LONG  = 2'd2
  } rl_class_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_P1   = 2'd1,
    SQ_P2   = 2'd2,
    SQ_FWD  = 2'd3
  } sq_state_t;

  localparam logic SEL_USER = 1'b0;
  localparam logic SEL_OS   = 1'b1;
endpackage

// File: rtl/rl_tracker.sv
module rl_tracker #(
  parameter int CNT_W = 32,
  parameter int ID_W  = 16,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             priv_enter,
  input  logic [ID_W-1:0]  call_id,
  input  logic             priv_exit,
  input  logic             insn_retire,
  output logic             in_priv,
  output logic [IDX_W-1:0] cur_idx,
  output logic [CNT_W-1:0] run_cnt,
  output logic             train_en
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             priv_q, priv_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  assign upd_en = priv_enter | priv_exit | insn_retire;

  always_comb begin
    priv_d = priv_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    if (priv_enter) begin
      priv_d = 1'b1;
      idx_d  = call_id[IDX_W-1:0];
      cnt_d  = '0;
    end else if (priv_q && priv_exit) begin
      priv_d = 1'b0;
    end else if (priv_q && insn_retire && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      priv_q <= priv_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
    end
  end

  assign in_priv  = priv_q;
  assign cur_idx  = idx_q;
  assign run_cnt  = cnt_q;
  assign train_en = priv_exit & priv_q & ~priv_enter;
endmodule

// File: rtl/rl_table.sv
module rl_table
  import steer_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             look_en,
  input  logic [IDX_W-1:0] look_idx,
  input  logic             train_en,
  input  logic [IDX_W-1:0] train_idx,
  input  logic [CNT_W-1:0] run_cnt,
  input  logic [CNT_W-1:0] thr_short,
  input  logic [CNT_W-1:0] thr_long,
  output rl_class_t        cur_class
);
  rl_class_t tbl [DEPTH];
  rl_class_t new_cls;
  rl_class_t cls_q;

  always_comb begin
    if (run_cnt <= thr_short)     new_cls = RL_SHORT;
    else if (run_cnt >= thr_long) new_cls = RL_LONG;
    else                          new_cls = RL_MOD;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = train_en && (train_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tbl[g] <= RL_SHORT;
      else if (wr_en) tbl[g] <= new_cls;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cls_q <= RL_SHORT;
    else if (look_en) cls_q <= tbl[look_idx];
  end

  assign cur_class = cls_q;
endmodule

// File: rtl/probe_seq.sv
module probe_seq
  import steer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              first_os,
  output logic              req_ready,
  output logic              probe_valid,
  output logic              probe_sel,
  input  logic              rsp_valid,
  input  logic              rsp_hit,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr
);
  sq_state_t         st_q, st_d;
  logic              sel_q, sel_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              take;

  assign take = (st_q == SQ_IDLE) && req_valid;

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    addr_d = addr_q;
    case (st_q)
      SQ_IDLE: if (req_valid) begin
        st_d   = SQ_P1;
        sel_d  = first_os ? SEL_OS : SEL_USER;
        addr_d = req_addr;
      end
      SQ_P1:   if (rsp_valid) st_d = rsp_hit ? SQ_IDLE : SQ_P2;
      SQ_P2:   if (rsp_valid) st_d = rsp_hit ? SQ_IDLE : SQ_FWD;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= SEL_USER;
      addr_q <= '0;
    end else if (take) begin
      sel_q  <= sel_d;
      addr_q <= addr_d;
    end
  end

  assign req_ready   = (st_q == SQ_IDLE);
  assign probe_valid = (st_q == SQ_P1) || (st_q == SQ_P2);
  assign probe_sel   = (st_q == SQ_P2) ? ~sel_q : sel_q;
  assign fwd_valid   = (st_q == SQ_FWD);
  assign fwd_addr    = addr_q;
endmodule

// File: rtl/syscall_steer_top.sv
module syscall_steer_top
  import steer_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 32,
  parameter int ID_W   = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              part_en,
  input  logic [CNT_W-1:0]  thr_short,
  input  logic [CNT_W-1:0]  thr_long,
  input  logic              priv_enter,
  input  logic [ID_W-1:0]   call_id,
  input  logic              priv_exit,
  input  logic              insn_retire,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              probe_valid,
  output logic              probe_sel,
  input  logic              rsp_valid,
  input  logic              rsp_hit,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr
);
  logic             in_priv;
  logic [IDX_W-1:0] cur_idx;
  logic [CNT_W-1:0] run_cnt;
  logic             train_en;
  rl_class_t        cur_class;
  logic             first_os;

  rl_tracker #(.CNT_W(CNT_W), .ID_W(ID_W), .IDX_W(IDX_W)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .priv_enter(priv_enter), .call_id(call_id),
    .priv_exit(priv_exit), .insn_retire(insn_retire),
    .in_priv(in_priv), .cur_idx(cur_idx),
    .run_cnt(run_cnt), .train_en(train_en)
  );

  rl_table #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .look_en(priv_enter), .look_idx(call_id[IDX_W-1:0]),
    .train_en(train_en), .train_idx(cur_idx),
    .run_cnt(run_cnt), .thr_short(thr_short), .thr_long(thr_long),
    .cur_class(cur_class)
  );

  assign first_os = part_en && in_priv && (cur_class == RL_MOD);

  probe_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .first_os(first_os),
    .req_ready(req_ready), .probe_valid(probe_valid), .probe_sel(probe_sel),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr)
  );
endmodule

// File: rtl/steer_chk.sv
module steer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             part_en,
  input logic             in_priv,
  input logic             priv_enter,
  input logic [CNT_W-1:0] run_cnt,
  input logic             req_valid,
  input logic             req_ready,
  input logic             probe_valid,
  input logic             probe_sel,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             fwd_valid
);
  // R2
  user_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !in_priv) |=> (probe_valid && !probe_sel));

  // R10
  nopart_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !part_en) |=> (probe_valid && !probe_sel));

  // R5
  cross_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && rsp_valid && !rsp_hit && !fwd_valid && $past(req_valid && req_ready))
      |=> (probe_valid && (probe_sel != $past(probe_sel))));

  // R5
  hit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && rsp_valid && rsp_hit) |=> (!probe_valid && !fwd_valid && req_ready));

  // R6
  fwd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |=> !fwd_valid);

  // R6
  fwd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_valid) |-> $past(probe_valid && rsp_valid && !rsp_hit));

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_enter |=> (in_priv && run_cnt == '0));

  // R12
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_priv && !priv_enter && run_cnt == {CNT_W{1'b1}}) |=> (run_cnt == {CNT_W{1'b1}}));
endmodule

bind syscall_steer_top steer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .part_en(part_en), .in_priv(in_priv),
  .priv_enter(priv_enter), .run_cnt(run_cnt),
  .req_valid(req_valid), .req_ready(req_ready),
  .probe_valid(probe_valid), .probe_sel(probe_sel),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .fwd_valid(fwd_valid)
);

// File: tb/sim_syscall_steer_top.sv
`timescale 1ns/1ps
module sim_syscall_steer_top;
  localparam int CNT_W = 8;
  localparam int ID_W = 8;
  localparam int ADDR_W = 16;
  localparam int NV = 10;

  // {call_id[8], retires[8], hit1, hit2, exp_os_first, exp_second, exp_fwd}
  localparam logic [20:0] VEC [NV] = '{
    {8'd5,  8'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R9 reset short
    {8'd5,  8'd10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R3 moderate
    {8'd5,  8'd2,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R4 long
    {8'd9,  8'd6,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'd9,  8'd0,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'd9,  8'd4,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'd9,  8'd7,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 4 -> moderate
    {8'd9,  8'd8,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 7 -> moderate
    {8'd9,  8'd3,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R7 8 -> long
    {8'd73, 8'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0}   // R1 alias slot 9, 3 -> short
  };

  logic clk, rst_n, part_en, priv_enter, priv_exit, insn_retire;
  logic [CNT_W-1:0] thr_short, thr_long;
  logic [ID_W-1:0] call_id;
  logic req_valid, req_ready, probe_valid, probe_sel, rsp_valid, rsp_hit, fwd_valid;
  logic [ADDR_W-1:0] req_addr, fwd_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic s1, p2, fw;
  logic [ADDR_W-1:0] fa;

  syscall_steer_top #(.DEPTH(64), .CNT_W(CNT_W), .ID_W(ID_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .part_en(part_en),
    .thr_short(thr_short), .thr_long(thr_long),
    .priv_enter(priv_enter), .call_id(call_id),
    .priv_exit(priv_exit), .insn_retire(insn_retire),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .probe_valid(probe_valid), .probe_sel(probe_sel),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic enter(input logic [ID_W-1:0] id);
    priv_enter = 1'b1; call_id = id;
    @(negedge clk);
    priv_enter = 1'b0;
  endtask

  task automatic leave();
    priv_exit = 1'b1;
    @(negedge clk);
    priv_exit = 1'b0;
  endtask

  task automatic retire(input int n);
    for (int k = 0; k < n; k++) begin
      insn_retire = 1'b1;
      @(negedge clk);
    end
    insn_retire = 1'b0;
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, input logic h1, input logic h2,
                        output logic o_s1, output logic o_p2, output logic o_fw,
                        output logic [ADDR_W-1:0] o_fa);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    o_s1 = probe_sel;
    chk("R5 first probe valid", {31'd0, probe_valid}, 32'd1);
    rsp_valid = 1'b1; rsp_hit = h1;
    @(negedge clk);
    rsp_valid = 1'b0;
    o_p2 = probe_valid; o_fw = 1'b0; o_fa = '0;
    if (o_p2) begin
      rsp_valid = 1'b1; rsp_hit = h2;
      @(negedge clk);
      rsp_valid = 1'b0;
      o_fw = fwd_valid; o_fa = fwd_addr;
      if (o_fw) @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; part_en = 1'b1; thr_short = 8'd3; thr_long = 8'd8;
    priv_enter = 0; priv_exit = 0; insn_retire = 0; call_id = '0;
    req_valid = 0; req_addr = '0; rsp_valid = 0; rsp_hit = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R9 no probe after reset", {31'd0, probe_valid}, 32'd0);
    chk("R9 no forward after reset", {31'd0, fwd_valid}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [20:0] e;
      e = VEC[v];
      enter(e[20:13]);
      access(16'h1000 + 16'(v), e[4], e[3], s1, p2, fw, fa);
      chk("R3 R4 first select", {31'd0, s1}, {31'd0, e[2]});
      chk("R5 second probe", {31'd0, p2}, {31'd0, e[1]});
      chk("R6 forward", {31'd0, fw}, {31'd0, e[0]});
      if (e[0]) chk("R6 forward address", {16'd0, fa}, {16'd0, 16'h1000 + 16'(v)});
      retire(int'(e[12:5]));
      leave();  // R8 training
    end

    // R2: moderate class does not affect user mode
    enter(8'd20); retire(5); leave();
    access(16'h2000, 1'b1, 1'b0, s1, p2, fw, fa);
    chk("R2 user mode user first", {31'd0, s1}, 32'd0);
    enter(8'd20);
    access(16'h2001, 1'b1, 1'b0, s1, p2, fw, fa);
    chk("R8 trained moderate kernel first", {31'd0, s1}, 32'd1);

    // R10
    part_en = 1'b0;
    access(16'h2002, 1'b0, 1'b0, s1, p2, fw, fa);
    chk("R10 disabled user first", {31'd0, s1}, 32'd0);
    chk("R10 disabled still forwards", {31'd0, fw}, 32'd1);
    part_en = 1'b1;
    access(16'h2003, 1'b1, 1'b0, s1, p2, fw, fa);
    chk("R10 reenabled kernel first", {31'd0, s1}, 32'd1);

    // R11 nested entry: 9 retires under 20, then 5 under 30
    retire(9); enter(8'd30); retire(5); leave();
    enter(8'd30);
    access(16'h2004, 1'b1, 1'b0, s1, p2, fw, fa);
    chk("R11 count restarted", {31'd0, s1}, 32'd1);
    leave();
    enter(8'd20);
    access(16'h2005, 1'b1, 1'b0, s1, p2, fw, fa);
    chk("R11 earlier training dropped", {31'd0, s1}, 32'd1);
    retire(5); leave();

    // R8 exit in user mode ignored (would retrain slot 20 short)
    thr_short = 8'd10;
    leave();
    thr_short = 8'd3;
    enter(8'd20);
    access(16'h2006, 1'b1, 1'b0, s1, p2, fw, fa);
    chk("R8 user-mode exit ignored", {31'd0, s1}, 32'd1);
    leave();

    // R12 saturation: 260 retires saturate to long, wrap would give 4 = moderate
    enter(8'd40); retire(260); leave();
    enter(8'd40);
    access(16'h2007, 1'b1, 1'b0, s1, p2, fw, fa);
    chk("R12 saturated count long", {31'd0, s1}, 32'd0);
    leave();

    // R5 busy: request ignored while probing
    req_valid = 1'b1; req_addr = 16'h3000;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 not ready while probing", {31'd0, req_ready}, 32'd0);
    rsp_valid = 1'b1; rsp_hit = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk("R5 hit returns idle", {31'd0, req_ready}, 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule